// File: doc/BRIEF.md
# Four-Channel Down-Counting Counter/Timer

The block holds four independent 8-bit down-counters behind one shared byte-wide write port. Each channel has an external input that serves either as a count clock or as a start trigger, and an output that pulses when the channel's count runs out. A channel either counts active edges of its external input (counter mode) or divides the system clock through a prescaler of 16 or 256 (timer mode). In timer mode the start can be held back until an active edge appears on the external input.

Software first writes a control word to a channel. If that word announces that a time constant follows, the next byte written to the same channel becomes the reload value. When the count reaches zero, the channel reloads the time constant, keeps running, emits a one-cycle pulse and, if its interrupt is enabled, raises a per-channel pending flag. That flag stays set until a per-channel acknowledge clears it. Vector generation and priority between interrupt sources belong to a neighbouring block.

Top module: `quad_count_timer`

## Requirements
- R1: While reset is low and after it is released, `zeroPulse` and `irqPend` are zero. No channel counts until a time constant has been written to it.
- R2: A byte with bit 0 = 1 is a control word, unless it is the awaited time constant. Its fields are: bit 7 interrupt enable, bit 6 mode (1 = counter, 0 = timer), bit 5 prescaler (1 = 256, 0 = 16), bit 4 active edge (1 = rising, 0 = falling), bit 3 trigger start (1 = wait for an edge), bit 2 time constant follows, bit 1 software stop. A byte with bit 0 = 0 that arrives when no time constant is awaited is ignored and leaves a running channel's timing unchanged.
- R3: In timer mode with automatic start, the first zero pulse is seen P·N cycles after the clock edge that writes the time constant. P is the prescale of 16 or 256 and N is the time constant. Later pulses follow every P·N cycles.
- R4: In counter mode, each active edge of the external input decrements the count. An input change made after clock edge k takes effect at edge k+3, because of two synchronising stages and one edge register.
- R5: With bit 4 = 0 only falling edges count, and rising edges are ignored.
- R6: In timer mode with trigger start, nothing counts until an active input edge appears. An input change after edge k starts the prescaler at edge k+3, and the first pulse follows P·N cycles after that.
- R7: A time constant of 0 acts as 256.
- R8: Each zero pulse lasts exactly one clock cycle. The count reloads and continues without software action.
- R9: A zero pulse sets that channel's `irqPend` one cycle later only when bit 7 was set. An `irqAck` bit clears the flag, and a new pulse in the same cycle wins over the acknowledge.
- R10: A control word with bit 1 set stops the channel. A control word with bit 2 set halts the channel until its time constant is written.
- R11: Channels run independently. Activity on one channel does not change the timing of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write strobe for one byte |
| wrSel | input | 2 | Channel addressed by the write |
| wrData | input | 8 | Control word or time constant |
| extIn | input | 4 | Per-channel external count clock or trigger, asynchronous |
| irqAck | input | 4 | Per-channel clear of the pending flag |
| zeroPulse | output | 4 | One-cycle pulse when a channel reaches zero |
| irqPend | output | 4 | Per-channel interrupt pending flag |

## Verification
The one-cycle pulse property only holds if each external input stays at every level for at least two system clock cycles, so that two active edges can never reach zero in back-to-back cycles. The bench therefore keeps every external level for two cycles, making one count pulse four cycles long. It changes inputs only at falling clock edges, so the three-edge input latency can be predicted exactly. The pending-flag properties assume nothing about the inputs, because the acknowledge may arrive in any cycle.

// File: rtl/qct_pkg.sv
package qct_pkg;

  // Per-channel strobes from control to datapath
  typedef struct packed {
    logic loadConst;  // load reload value and count this cycle
    logic run;        // channel is counting
    logic countMode;  // 1: count external edges, 0: prescaled timer
    logic longPre;    // 1: prescale 256, 0: prescale 16
    logic riseEdge;   // 1: rising edge active, 0: falling
  } chanStrobe_t;

  // Control word field positions
  localparam int CW_MARK  = 0;
  localparam int CW_STOP  = 1;
  localparam int CW_CONST = 2;
  localparam int CW_TRIG  = 3;
  localparam int CW_RISE  = 4;
  localparam int CW_LONG  = 5;
  localparam int CW_COUNT = 6;
  localparam int CW_IRQEN = 7;

endpackage

// File: rtl/qct_ctrl.sv
module qct_ctrl
  import qct_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 8,
  localparam int SEL_W = $clog2(NUM_CH)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     wrEn,
  input  logic [SEL_W-1:0]         wrSel,
  input  logic [DATA_W-1:0]        wrData,
  input  logic [NUM_CH-1:0]        edgeHit,
  input  logic [NUM_CH-1:0]        zeroHit,
  input  logic [NUM_CH-1:0]        irqAck,
  output chanStrobe_t [NUM_CH-1:0] strobe,
  output logic [NUM_CH-1:0]        irqPend
);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic irqEn, countMode, longPre, riseEdge, trigStart;
    logic waitConst, running, armed, pend;
    logic hit;
    chanStrobe_t chStrobe;

    assign hit = wrEn && (wrSel == SEL_W'(c));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        irqEn     <= 1'b0;
        countMode <= 1'b0;
        longPre   <= 1'b0;
        riseEdge  <= 1'b0;
        trigStart <= 1'b0;
        waitConst <= 1'b0;
        running   <= 1'b0;
        armed     <= 1'b0;
        pend      <= 1'b0;
      end else begin
        if (hit && waitConst) begin
          // awaited byte is the time constant
          waitConst <= 1'b0;
          if (!countMode && trigStart) begin
            armed   <= 1'b1;
            running <= 1'b0;
          end else begin
            armed   <= 1'b0;
            running <= 1'b1;
          end
        end else if (hit && wrData[CW_MARK]) begin
          irqEn     <= wrData[CW_IRQEN];
          countMode <= wrData[CW_COUNT];
          longPre   <= wrData[CW_LONG];
          riseEdge  <= wrData[CW_RISE];
          trigStart <= wrData[CW_TRIG];
          waitConst <= wrData[CW_CONST];
          if (wrData[CW_STOP] || wrData[CW_CONST]) begin
            running <= 1'b0;
            armed   <= 1'b0;
          end
        end else if (armed && !countMode && edgeHit[c]) begin
          armed   <= 1'b0;
          running <= 1'b1;
        end
        pend <= (zeroHit[c] && irqEn) || (pend && !irqAck[c]);
      end
    end

    always_comb begin
      chStrobe.loadConst = hit && waitConst;
      chStrobe.run       = running;
      chStrobe.countMode = countMode;
      chStrobe.longPre   = longPre;
      chStrobe.riseEdge  = riseEdge;
    end

    assign strobe[c]  = chStrobe;
    assign irqPend[c] = pend;
  end

endmodule

// File: rtl/qct_path.sv
module qct_path
  import qct_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int DATA_W      = 8,
  parameter int PRE_SHORT   = 16,
  parameter int PRE_LONG    = 256,
  parameter int SYNC_STAGES = 2,
  localparam int PSC_W      = $clog2(PRE_LONG)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_CH-1:0]        extIn,
  input  logic [DATA_W-1:0]        wrData,
  input  chanStrobe_t [NUM_CH-1:0] strobe,
  output logic [NUM_CH-1:0]        edgeHit,
  output logic [NUM_CH-1:0]        zeroPulse
);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [SYNC_STAGES-1:0] syncQ;
    logic                   lastLvl, curLvl;
    logic [DATA_W-1:0]      reloadVal, count;
    logic [PSC_W-1:0]       psc;
    logic                   pscLast, tick, zeroQ;

    // input synchroniser and edge register
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncQ   <= '0;
        lastLvl <= 1'b0;
      end else begin
        syncQ   <= {syncQ[SYNC_STAGES-2:0], extIn[c]};
        lastLvl <= syncQ[SYNC_STAGES-1];
      end
    end

    assign curLvl     = syncQ[SYNC_STAGES-1];
    assign edgeHit[c] = strobe[c].riseEdge ? (curLvl && !lastLvl)
                                           : (!curLvl && lastLvl);

    assign pscLast = strobe[c].longPre ? (psc == PSC_W'(PRE_LONG - 1))
                                       : (psc == PSC_W'(PRE_SHORT - 1));
    assign tick    = strobe[c].run &&
                     (strobe[c].countMode ? edgeHit[c] : pscLast);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        reloadVal <= '0;
        count     <= '0;
        psc       <= '0;
        zeroQ     <= 1'b0;
      end else if (strobe[c].loadConst) begin
        reloadVal <= wrData;
        count     <= wrData;
        psc       <= '0;
        zeroQ     <= 1'b0;
      end else begin
        zeroQ <= tick && (count == DATA_W'(1));
        if (tick)
          count <= (count == DATA_W'(1)) ? reloadVal : count - 1'b1;
        if (strobe[c].run && !strobe[c].countMode)
          psc <= pscLast ? '0 : psc + 1'b1;
        else
          psc <= '0;
      end
    end

    assign zeroPulse[c] = zeroQ;
  end

endmodule

// File: rtl/quad_count_timer.sv
module quad_count_timer
  import qct_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int DATA_W      = 8,
  parameter int PRE_SHORT   = 16,
  parameter int PRE_LONG    = 256,
  parameter int SYNC_STAGES = 2,
  localparam int SEL_W      = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [SEL_W-1:0]  wrSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic [NUM_CH-1:0] extIn,
  input  logic [NUM_CH-1:0] irqAck,
  output logic [NUM_CH-1:0] zeroPulse,
  output logic [NUM_CH-1:0] irqPend
);

  chanStrobe_t [NUM_CH-1:0] strobe;
  logic [NUM_CH-1:0]        edgeHit;

  qct_ctrl #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .edgeHit(edgeHit), .zeroHit(zeroPulse), .irqAck(irqAck),
    .strobe(strobe), .irqPend(irqPend)
  );

  qct_path #(
    .NUM_CH(NUM_CH), .DATA_W(DATA_W), .PRE_SHORT(PRE_SHORT),
    .PRE_LONG(PRE_LONG), .SYNC_STAGES(SYNC_STAGES)
  ) u_path (
    .clk(clk), .rstN(rstN), .extIn(extIn), .wrData(wrData),
    .strobe(strobe), .edgeHit(edgeHit), .zeroPulse(zeroPulse)
  );

endmodule

// File: rtl/qct_checker.sv
module qct_checker #(
  parameter int NUM_CH = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic [NUM_CH-1:0] zeroPulse,
  input logic [NUM_CH-1:0] irqPend,
  input logic [NUM_CH-1:0] irqAck
);

  // R1: outputs quiet at the first edge after reset release
  p_reset_quiet_r1: assert property (@(posedge clk)
    $rose(rstN) |-> (zeroPulse == '0 && irqPend == '0));

  // R8: no channel pulses in two consecutive cycles
  p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    (zeroPulse != '0) |=> ((zeroPulse & $past(zeroPulse)) == '0));

  // R9: a pending flag only rises after that channel's zero pulse
  p_pend_source_r9: assert property (@(posedge clk) disable iff (!rstN)
    ((irqPend & ~$past(irqPend) & ~$past(zeroPulse)) == '0));

  // R9: acknowledge without a coincident pulse clears the flag
  p_ack_clears_r9: assert property (@(posedge clk) disable iff (!rstN)
    (irqAck != '0) |=> ((irqPend & $past(irqAck) & ~$past(zeroPulse)) == '0));

endmodule

bind quad_count_timer qct_checker #(.NUM_CH(NUM_CH)) u_qct_checker (
  .clk(clk), .rstN(rstN), .zeroPulse(zeroPulse),
  .irqPend(irqPend), .irqAck(irqAck)
);

// File: tb/quad_count_timer_test.sv
module quad_count_timer_test;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] wrSel = '0;
  logic [7:0] wrData = '0;
  logic [3:0] extIn = '0;
  logic [3:0] irqAck = '0;
  logic [3:0] zeroPulse, irqPend;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  int expQ [4][$];
  int pulseCnt [4] = '{0, 0, 0, 0};
  logic [3:0] prevZ = '0;

  quad_count_timer uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .extIn(extIn), .irqAck(irqAck), .zeroPulse(zeroPulse), .irqPend(irqPend)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: pops expected pulse cycles per channel
  always @(negedge clk) begin
    if (rstN) begin
      for (int c = 0; c < 4; c++) begin
        if (zeroPulse[c]) begin
          pulseCnt[c]++;
          check(!prevZ[c], $sformatf("R8 one-cycle pulse ch%0d", c), 1, 0);
          if (expQ[c].size() == 0)
            check(1'b0, $sformatf("R11 unexpected pulse ch%0d", c), cyc, -1);
          else begin
            int e;
            e = expQ[c].pop_front();
            check(cyc == e, $sformatf("zero pulse cycle ch%0d", c), cyc, e);
          end
        end
      end
      prevZ <= zeroPulse;
    end
  end

  task automatic wr(input int ch, input logic [7:0] d, output int at);
    @(negedge clk);
    wrEn = 1'b1; wrSel = 2'(ch); wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    at = cyc;
  endtask

  task automatic edgePulse(input int ch, input bit push, input int delay, output int k);
    @(negedge clk);
    extIn[ch] = 1'b1;
    k = cyc;
    if (push) expQ[ch].push_back(cyc + delay);
    repeat (2) @(negedge clk);
    extIn[ch] = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic waitUntil(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic ack(input int ch);
    @(negedge clk);
    irqAck[ch] = 1'b1;
    @(negedge clk);
    irqAck[ch] = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int w, w2, k, dummy, base;
    // R1 reset state
    repeat (3) @(negedge clk);
    check(zeroPulse == 4'b0, "R1 pulse in reset", int'(zeroPulse), 0);
    check(irqPend == 4'b0, "R1 pend in reset", int'(irqPend), 0);
    rstN = 1'b1;
    repeat (40) @(negedge clk);
    check(pulseCnt[0] + pulseCnt[1] + pulseCnt[2] + pulseCnt[3] == 0,
          "R1 idle before constant", pulseCnt[0], 0);

    // R3/R9/R10: timer prescale 16, irq on, N=3 on ch0
    wr(0, 8'h85, dummy);
    wr(0, 8'd3, w);
    expQ[0].push_back(w + 48);
    expQ[0].push_back(w + 96);
    waitUntil(w + 98);
    check(pulseCnt[0] == 2, "R3 timer pulses ch0", pulseCnt[0], 2);
    check(irqPend[0] == 1'b1, "R9 pend set ch0", int'(irqPend[0]), 1);
    ack(0);
    check(irqPend[0] == 1'b0, "R9 ack clears ch0", int'(irqPend[0]), 0);
    wr(0, 8'h03, dummy);
    repeat (200) @(negedge clk);
    check(pulseCnt[0] == 2, "R10 stop ch0", pulseCnt[0], 2);

    // R2/R11/R3: ch1 prescale 16 no irq, ch2 prescale 256
    wr(1, 8'h05, dummy);
    wr(1, 8'd2, w);
    expQ[1].push_back(w + 32);
    expQ[1].push_back(w + 64);
    expQ[1].push_back(w + 96);
    wr(2, 8'h25, dummy);
    wr(2, 8'd2, w2);
    expQ[2].push_back(w2 + 512);
    waitUntil(w + 40);
    wr(1, 8'h40, dummy);
    waitUntil(w + 98);
    check(pulseCnt[1] == 3, "R2 ignored byte keeps ch1 timing", pulseCnt[1], 3);
    check(irqPend[1] == 1'b0, "R9 no pend when disabled ch1", int'(irqPend[1]), 0);
    wr(1, 8'h03, dummy);
    waitUntil(w2 + 514);
    check(pulseCnt[2] == 1, "R11 ch2 prescale 256 alongside ch1", pulseCnt[2], 1);
    wr(2, 8'h03, dummy);

    // R4: counter mode rising, N=3 on ch3 with irq
    wr(3, 8'hD5, dummy);
    wr(3, 8'd3, dummy);
    edgePulse(3, 0, 0, k);
    edgePulse(3, 0, 0, k);
    edgePulse(3, 1, 3, k);
    check(pulseCnt[3] == 1, "R4 counter reaches zero ch3", pulseCnt[3], 1);
    check(irqPend[3] == 1'b1, "R9 pend set ch3", int'(irqPend[3]), 1);
    ack(3);
    check(irqPend[3] == 1'b0, "R9 ack clears ch3", int'(irqPend[3]), 0);
    edgePulse(3, 0, 0, k);
    edgePulse(3, 0, 0, k);
    edgePulse(3, 1, 3, k);
    check(pulseCnt[3] == 2, "R8 reload after zero ch3", pulseCnt[3], 2);

    // R5: falling edge, N=2
    wr(3, 8'hC5, dummy);
    wr(3, 8'd2, dummy);
    edgePulse(3, 0, 0, k);
    edgePulse(3, 1, 5, k);
    repeat (3) @(negedge clk);
    check(pulseCnt[3] == 3, "R5 falling edges counted ch3", pulseCnt[3], 3);
    wr(3, 8'h03, dummy);

    // R7: constant 0 acts as 256, counter rising, ch2 no irq
    wr(2, 8'h55, dummy);
    wr(2, 8'd0, dummy);
    base = pulseCnt[2];
    for (int i = 0; i < 255; i++) edgePulse(2, 0, 0, k);
    check(pulseCnt[2] == base, "R7 no pulse after 255 edges", pulseCnt[2], base);
    edgePulse(2, 1, 3, k);
    check(pulseCnt[2] == base + 1, "R7 pulse at 256th edge", pulseCnt[2], base + 1);
    check(irqPend[2] == 1'b0, "R9 no pend ch2", int'(irqPend[2]), 0);
    wr(2, 8'h03, dummy);

    // R6: trigger start, rising, prescale 16, N=2 on ch0
    wr(0, 8'h1D, dummy);
    wr(0, 8'd2, w);
    base = pulseCnt[0];
    waitUntil(w + 50);
    check(pulseCnt[0] == base, "R6 waits for trigger", pulseCnt[0], base);
    edgePulse(0, 1, 35, k);
    expQ[0].push_back(k + 67);
    waitUntil(k + 70);
    check(pulseCnt[0] == base + 2, "R6 triggered pulses ch0", pulseCnt[0], base + 2);
    wr(0, 8'h03, dummy);
    repeat (40) @(negedge clk);

    for (int c = 0; c < 4; c++)
      check(expQ[c].size() == 0, $sformatf("R3 missing pulses ch%0d", c),
            expQ[c].size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule